// File: doc/BRIEF.md
# Cascadable Segment Register Loader

This block sits behind a serial bus slave front end that has already decoded the bus address and the bit-level framing. The front end hands over a start strobe, a byte-valid strobe with its data byte, and a stop strobe. The block holds one control byte and eight segment bytes. It passes a bank of four segment bytes and a drive-mode flag to a display output stage.

The first byte of every transfer is a control byte. Every chip on the bus takes it, so all chips share the same drive mode, shown bank and 6-bit load pointer. The upper three pointer bits name a chip and the lower three name one of its registers. Each following byte is a segment byte. Only the chip whose strapped subaddress equals the pointer's chip field stores it, but every chip steps its pointer. A run of bytes therefore moves from one chip to the next when the subaddresses are numbered contiguously.

Top module: `seg_loader_top`

## Requirements
- R1: After reset every register holds zero: `disp_bytes` is 0, `duplex_mode` is 0 (direct drive), bank A is shown and the pointer is 0.
- R2: The first accepted byte after `xfer_start` is a control byte. Bit 7 sets duplex drive (1 = duplex), bit 6 selects the shown bank (1 = bank B), and bits 5..0 load the pointer. `duplex_mode` follows bit 7 from the next clock edge.
- R3: A segment byte whose pointer bits 5..3 equal `sub_addr` in direct mode is stored in segment register number pointer[2:0]. It is visible from the next clock edge.
- R4: A segment byte whose chip field does not match leaves every segment register unchanged.
- R5: The pointer goes up by one after every segment byte, whether it matched or not. A carry out of bits 2..0 moves loading to the next chip number, and the pointer wraps from 63 to 0.
- R6: In duplex mode `sub_addr[2]` and pointer bit 5 are ignored. A match needs only pointer bits 4..3 to equal `sub_addr[1:0]`.
- R7: `disp_bytes` byte k (bits 8k+7..8k) shows segment register 2k when bank A is selected and register 2k+1 when bank B is selected.
- R8: After `xfer_stop`, bytes are ignored until the next `xfer_start`. A repeated `xfer_start` in the middle of a transfer makes the next byte a control byte again.
- R9: A byte strobe in the same cycle as `xfer_start` or `xfer_stop` is dropped. The start or stop takes effect, and if both strobes come together the stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_addr | input | 3 | Strapped chip subaddress |
| xfer_start | input | 1 | One-cycle pulse: this chip was addressed (start or repeated start) |
| xfer_stop | input | 1 | One-cycle pulse: the transfer ended |
| byte_valid | input | 1 | One-cycle pulse: `byte_data` holds a received byte |
| byte_data | input | 8 | Received data byte |
| disp_bytes | output | 32 | The four bytes of the shown bank, register order, byte 0 lowest |
| duplex_mode | output | 1 | 1 = duplex drive, 0 = direct drive |

## Verification
The assertions assume that each strobe lasts one cycle. They also assume that `sub_addr` holds steady while a transfer is running, because the match is evaluated on every segment byte. The bench changes `sub_addr` only between transfers. It drives every strobe for exactly one clock and raises strobes together only in the scenario that checks the collision rule on purpose.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int BYTE_W = 8;
    localparam int SUB_W  = 3;
    localparam int IDX_W  = 3;
    localparam int VEC_W  = SUB_W + IDX_W;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_CTRL = 2'd1,
        XF_DATA = 2'd2
    } xfer_st_e;

    typedef struct packed {
        logic             duplex;
        logic             bank_b;
        logic [VEC_W-1:0] vec;
    } ctrl_t;
endpackage

// File: rtl/seg_ptr_ctrl.sv
module seg_ptr_ctrl
    import seg_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    output ctrl_t             ctrl,
    output logic              seg_strobe
);
    localparam logic [VEC_W-1:0] VEC_ONE = VEC_W'(1);

    typedef struct packed {
        xfer_st_e st;
        ctrl_t    ctrl;
    } ptr_state_t;

    ptr_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        seg_strobe = 1'b0;
        if (xfer_stop) begin
            s_d.st = XF_IDLE;
        end else if (xfer_start) begin
            s_d.st = XF_CTRL;
        end else if (byte_valid) begin
            case (s_q.st)
                XF_CTRL: begin
                    s_d.ctrl = ctrl_t'(byte_data);
                    s_d.st   = XF_DATA;
                end
                XF_DATA: begin
                    seg_strobe   = 1'b1;
                    s_d.ctrl.vec = s_q.ctrl.vec + VEC_ONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: XF_IDLE, ctrl: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl = s_q.ctrl;

    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == XF_CTRL && byte_valid && !xfer_start && !xfer_stop)
        |=> (ctrl == $past(byte_data)));

    // R5
    vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_strobe |=> (ctrl.vec == $past(ctrl.vec) + VEC_ONE));

    // R8
    start_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !xfer_stop) |=> (s_q.st == XF_CTRL));

    // R9
    collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && (xfer_start || xfer_stop)) |=> $stable(ctrl));
endmodule

// File: rtl/seg_addr_match.sv
module seg_addr_match
    import seg_pkg::*;
#(
    parameter int ADDR_W = SUB_W
) (
    input  logic [ADDR_W-1:0] dev_field,
    input  logic [ADDR_W-1:0] sub_addr,
    input  logic              duplex,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        if (i == ADDR_W - 1) begin : g_top
            assign bit_ok[i] = duplex | (dev_field[i] == sub_addr[i]);
        end else begin : g_low
            assign bit_ok[i] = (dev_field[i] == sub_addr[i]);
        end
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/seg_bank_regs.sv
module seg_bank_regs
    import seg_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int SEL_W  = IDX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [SEL_W-1:0]                  widx,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              bank_b,
    output logic [((1<<SEL_W)/2)*DATA_W-1:0]  disp
);
    localparam int NUM_SEG = 1 << SEL_W;
    localparam int BANK_N  = NUM_SEG / 2;

    typedef struct packed {
        logic [NUM_SEG-1:0][DATA_W-1:0] seg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            r_d.seg[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar k = 0; k < BANK_N; k++) begin : g_bank
        assign disp[k*DATA_W +: DATA_W] = bank_b ? r_q.seg[2*k+1] : r_q.seg[2*k];
    end

    // R3
    seg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (r_q.seg[$past(widx)] == $past(wdata)));

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(r_q.seg));
endmodule

// File: rtl/seg_loader_top.sv
module seg_loader_top
    import seg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SUB_W-1:0]         sub_addr,
    input  logic                     xfer_start,
    input  logic                     xfer_stop,
    input  logic                     byte_valid,
    input  logic [BYTE_W-1:0]        byte_data,
    output logic [4*BYTE_W-1:0]      disp_bytes,
    output logic                     duplex_mode
);
    ctrl_t ctrl;
    logic  seg_strobe;
    logic  dev_hit;
    logic  seg_we;

    seg_ptr_ctrl #(.DATA_W(BYTE_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_stop  (xfer_stop),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .ctrl       (ctrl),
        .seg_strobe (seg_strobe)
    );

    seg_addr_match #(.ADDR_W(SUB_W)) u_match (
        .dev_field (ctrl.vec[VEC_W-1:IDX_W]),
        .sub_addr  (sub_addr),
        .duplex    (ctrl.duplex),
        .hit       (dev_hit)
    );

    assign seg_we = seg_strobe & dev_hit;

    seg_bank_regs #(.DATA_W(BYTE_W), .SEL_W(IDX_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (seg_we),
        .widx   (ctrl.vec[IDX_W-1:0]),
        .wdata  (byte_data),
        .bank_b (ctrl.bank_b),
        .disp   (disp_bytes)
    );

    assign duplex_mode = ctrl.duplex;

    // R6
    duplex_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_strobe && ctrl.duplex &&
         ctrl.vec[VEC_W-2:IDX_W] == sub_addr[SUB_W-2:0]) |-> seg_we);

    // R4
    direct_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.duplex && ctrl.vec[VEC_W-1:IDX_W] != sub_addr) |-> !seg_we);
endmodule

// File: tb/tb_seg_loader_top.sv
module tb_seg_loader_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sub_addr = 3'b010;
    logic        xfer_start = 1'b0;
    logic        xfer_stop = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [31:0] disp_bytes;
    logic        duplex_mode;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_loader_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sub_addr    (sub_addr),
        .xfer_start  (xfer_start),
        .xfer_stop   (xfer_stop),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .disp_bytes  (disp_bytes),
        .duplex_mode (duplex_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); xfer_stop = 1'b1;
        @(negedge clk); xfer_stop = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 disp after reset", disp_bytes, 32'h0);
        chk("R1 mode after reset", {31'b0, duplex_mode}, 32'h0);
    endtask

    task automatic t_direct_load();
        do_start();
        do_byte(8'h10);
        chk("R2 mode from control bit7=0", {31'b0, duplex_mode}, 32'h0);
        do_byte(8'hA0); do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
        chk("R3 R7 bank A after direct load", disp_bytes, 32'h0000A2A0);
        do_stop();
    endtask

    task automatic t_bank_b_and_miss();
        do_start();
        do_byte(8'h54);
        do_byte(8'hB4); do_byte(8'hB5); do_byte(8'hB6); do_byte(8'hB7);
        do_byte(8'hEE);
        chk("R7 R4 bank B view, chip 3 byte dropped", disp_bytes, 32'hB7B5A3A1);
        do_stop();
    endtask

    task automatic t_carry();
        do_start();
        do_byte(8'h0F);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
        chk("R5 carry into next chip", disp_bytes, 32'hB6B4A222);
        do_stop();
    endtask

    task automatic t_wrap();
        sub_addr = 3'b000;
        do_start();
        do_byte(8'h3F);
        do_byte(8'h5A); do_byte(8'hC3);
        chk("R5 pointer wraps 63 to 0", disp_bytes, 32'hB6B4A2C3);
        do_stop();
    endtask

    task automatic t_duplex();
        sub_addr = 3'b110;
        do_start();
        do_byte(8'h92);
        chk("R2 mode from control bit7=1", {31'b0, duplex_mode}, 32'h1);
        do_byte(8'h7E);
        chk("R6 duplex ignores top bit", disp_bytes, 32'hB6B47EC3);
        do_stop();
        do_start();
        do_byte(8'h12);
        do_byte(8'h55);
        chk("R6 direct mode uses top bit", disp_bytes, 32'hB6B47EC3);
        chk("R2 mode back to direct", {31'b0, duplex_mode}, 32'h0);
        do_stop();
    endtask

    task automatic t_stop_restart();
        do_byte(8'hFF);
        chk("R8 byte ignored while idle (mode)", {31'b0, duplex_mode}, 32'h0);
        chk("R8 byte ignored while idle (disp)", disp_bytes, 32'hB6B47EC3);
        do_start();
        do_byte(8'hC0);
        chk("R8 first byte is control (mode)", {31'b0, duplex_mode}, 32'h1);
        chk("R8 first byte is control (bank B)", disp_bytes, 32'hB7B5A333);
        do_byte(8'h01);
        do_start();
        do_byte(8'h00);
        chk("R8 repeated start reloads control", {31'b0, duplex_mode}, 32'h0);
        chk("R8 repeated start bank A view", disp_bytes, 32'hB6B47EC3);
        do_stop();
    endtask

    task automatic t_collision();
        sub_addr = 3'b010;
        do_start();
        do_byte(8'h10);
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'h99; xfer_start = 1'b1;
        @(negedge clk); byte_valid = 1'b0; xfer_start = 1'b0;
        do_byte(8'h10);
        do_byte(8'h44);
        chk("R9 byte with start dropped", disp_bytes, 32'hB6B47E44);
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'h88; xfer_stop = 1'b1;
        @(negedge clk); byte_valid = 1'b0; xfer_stop = 1'b0;
        do_start();
        do_byte(8'h51);
        chk("R9 byte with stop dropped", disp_bytes, 32'hB7B5A333);
        do_stop();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog R1..all timed out actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct_load();
        t_bank_b_and_miss();
        t_carry();
        t_wrap();
        t_duplex();
        t_stop_restart();
        t_collision();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule